// File: doc/BRIEF.md
# 32-bit Integer ALU with Multiply

This block is the combinational arithmetic unit of a RISC-V style execute stage. It takes two 32-bit operands and a 4-bit operation code and returns one 32-bit result in the same cycle. The operations are add, subtract, the three bitwise operations, three shifts, signed set-less-than, the low word and two high-word variants of the full product, and a pass-through of the second operand. The pass-through lets a load-upper-immediate instruction use the same write-back path.

Each operation has its own function unit, and a decoded control word picks the unit's output. Subtract and signed compare share one adder. All three shifts share one right shifter. All three multiply codes share one multiplier whose operands are widened by one bit. There is no clock, no flag output and no division.

Top module: `rv32_alu`

## Requirements
- R1: With op_sel = 0, result is op_a + op_b modulo 2^32.
- R2: With op_sel = 12, result is op_a - op_b modulo 2^32.
- R3: With op_sel = 4, 6 and 7, result is op_a XOR, OR and AND op_b, bit by bit.
- R4: With op_sel = 1, result is op_a shifted left by op_b[4:0] with zeros shifted in. Bits op_b[31:5] have no effect on the shift.
- R5: With op_sel = 5, result is op_a shifted right by op_b[4:0] with zeros shifted in.
- R6: With op_sel = 13, result is op_a shifted right by op_b[4:0]. Every vacated bit takes the value of op_a[31], for all amounts 0 to 31.
- R7: With op_sel = 2, result is 1 when op_a < op_b as two's-complement numbers and 0 otherwise. This includes operands on opposite sides of 0x80000000/0x7FFFFFFF, where the difference overflows.
- R8: With op_sel = 8, result is bits 31:0 of op_a * op_b.
- R9: With op_sel = 9, result is bits 63:32 of the product of op_a and op_b, both taken as signed.
- R10: With op_sel = 11, result is bits 63:32 of the product of op_a and op_b, both taken as unsigned.
- R11: With op_sel = 15, result equals op_b unchanged.
- R12: With op_sel = 3, 10 or 14, result is 0 whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; its low 5 bits give the shift amount |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Output of the selected operation |

## Verification
Every operation code is run against a grid of corner operands: 0, 1, all ones, 0x80000000, 0x7FFFFFFF and an alternating pattern. Many random operands follow. The 0x80000000/0x7FFFFFFF pairs target a set-less-than that reads the raw sign of the difference; such a design reports the wrong order when the subtraction overflows. The all-ones operands target the high product words. If the shared multiplier widens the operands with the wrong extension, mulh of -1 by -1 becomes nonzero, or mulhu returns 0 where 0xFFFFFFFE is expected. Shift amounts of 0 and 31, together with op_b values that have bits set above bit 4, show whether a shifter uses too many bits of the amount, and whether the arithmetic shift loses the sign fill at its widest shift.

// File: rtl/rv32_alu_pkg.sv
package rv32_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SLL   = 4'd1,
        OP_SLT   = 4'd2,
        OP_NONE3 = 4'd3,
        OP_XOR   = 4'd4,
        OP_SRL   = 4'd5,
        OP_OR    = 4'd6,
        OP_AND   = 4'd7,
        OP_MUL   = 4'd8,
        OP_MULH  = 4'd9,
        OP_NONEA = 4'd10,
        OP_MULHU = 4'd11,
        OP_SUB   = 4'd12,
        OP_SRA   = 4'd13,
        OP_NONEE = 4'd14,
        OP_PASSB = 4'd15
    } alu_op_e;

    typedef enum logic [3:0] {
        SRC_SUM,
        SRC_LT,
        SRC_XOR,
        SRC_OR,
        SRC_AND,
        SRC_SHIFT,
        SRC_MULLO,
        SRC_MULHI,
        SRC_PASSB,
        SRC_ZERO
    } res_src_e;

    typedef struct packed {
        logic     sub_en;
        logic     shl_en;
        logic     sra_en;
        logic     mul_signed;
        res_src_e src;
    } alu_ctrl_t;

endpackage

// File: rtl/rv32_alu_decode.sv
module rv32_alu_decode
    import rv32_alu_pkg::*;
(
    input  logic [3:0] op_sel,
    output alu_ctrl_t  ctrl
);

    always_comb begin
        ctrl            = '0;
        ctrl.src        = SRC_ZERO;
        case (alu_op_e'(op_sel))
            OP_ADD:   ctrl.src = SRC_SUM;
            OP_SUB: begin
                ctrl.sub_en = 1'b1;
                ctrl.src    = SRC_SUM;
            end
            OP_SLT: begin
                ctrl.sub_en = 1'b1;
                ctrl.src    = SRC_LT;
            end
            OP_XOR:   ctrl.src = SRC_XOR;
            OP_OR:    ctrl.src = SRC_OR;
            OP_AND:   ctrl.src = SRC_AND;
            OP_SLL: begin
                ctrl.shl_en = 1'b1;
                ctrl.src    = SRC_SHIFT;
            end
            OP_SRL:   ctrl.src = SRC_SHIFT;
            OP_SRA: begin
                ctrl.sra_en = 1'b1;
                ctrl.src    = SRC_SHIFT;
            end
            OP_MUL:   ctrl.src = SRC_MULLO;
            OP_MULH: begin
                ctrl.mul_signed = 1'b1;
                ctrl.src        = SRC_MULHI;
            end
            OP_MULHU: ctrl.src = SRC_MULHI;
            OP_PASSB: ctrl.src = SRC_PASSB;
            default:  ctrl.src = SRC_ZERO;
        endcase
    end

endmodule

// File: rtl/rv32_alu_addsub.sv
module rv32_alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub_en,
    output logic [XLEN-1:0] sum,
    output logic            lt_signed
);

    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] b_inv;
    logic [XLEN:0]   full;
    logic            unused_carry;

    always_comb begin
        b_inv        = b ^ {XLEN{sub_en}};
        full         = {1'b0, a} + {1'b0, b_inv} + {{XLEN{1'b0}}, sub_en};
        sum          = full[XLEN-1:0];
        unused_carry = full[XLEN];
        // When the signs differ the difference may overflow, so the operand
        // signs decide; otherwise the sign of the difference is exact.
        lt_signed    = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];
    end

endmodule

// File: rtl/rv32_alu_shift.sv
module rv32_alu_shift #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]         a,
    input  logic [$clog2(XLEN)-1:0] shamt,
    input  logic                    shl_en,
    input  logic                    sra_en,
    output logic [XLEN-1:0]         res
);

    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0]   a_rev;
    logic [XLEN-1:0]   src;
    logic [XLEN-1:0]   shr;
    logic [XLEN-1:0]   shr_rev;
    logic [2*XLEN-1:0] wide;
    logic [XLEN-1:0]   unused_hi;
    logic              fill;

    // Bit reversal so that one right shifter serves left shifts too.
    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign a_rev[i]   = a[MSB-i];
        assign shr_rev[i] = shr[MSB-i];
    end

    always_comb begin
        src       = shl_en ? a_rev : a;
        fill      = sra_en & a[MSB];
        wide      = {{XLEN{fill}}, src} >> shamt;
        shr       = wide[XLEN-1:0];
        unused_hi = wide[2*XLEN-1:XLEN];
        res       = shl_en ? shr_rev : shr;
    end

endmodule

// File: rtl/rv32_alu_mul.sv
module rv32_alu_mul #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            is_signed,
    output logic [XLEN-1:0] lo,
    output logic [XLEN-1:0] hi
);

    localparam int MSB = XLEN - 1;
    localparam int PW  = 2 * XLEN + 2;

    logic signed [XLEN:0] a_x;
    logic signed [XLEN:0] b_x;
    logic signed [PW-1:0] prod;
    logic [1:0]           unused_top;

    always_comb begin
        // One extra bit: sign copy for signed codes, zero otherwise.
        a_x        = $signed({is_signed & a[MSB], a});
        b_x        = $signed({is_signed & b[MSB], b});
        prod       = a_x * b_x;
        lo         = prod[XLEN-1:0];
        hi         = prod[2*XLEN-1:XLEN];
        unused_top = prod[PW-1:2*XLEN];
    end

endmodule

// File: rtl/rv32_alu.sv
module rv32_alu
    import rv32_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [3:0]      op_sel,
    output logic [XLEN-1:0] result
);

    localparam int SHW = $clog2(XLEN);

    alu_ctrl_t       ctrl;
    logic [XLEN-1:0] sum;
    logic            lt;
    logic [XLEN-1:0] sh_res;
    logic [XLEN-1:0] mul_lo;
    logic [XLEN-1:0] mul_hi;

    rv32_alu_decode u_dec (
        .op_sel (op_sel),
        .ctrl   (ctrl)
    );

    rv32_alu_addsub #(.XLEN(XLEN)) u_add (
        .a         (op_a),
        .b         (op_b),
        .sub_en    (ctrl.sub_en),
        .sum       (sum),
        .lt_signed (lt)
    );

    rv32_alu_shift #(.XLEN(XLEN)) u_sh (
        .a      (op_a),
        .shamt  (op_b[SHW-1:0]),
        .shl_en (ctrl.shl_en),
        .sra_en (ctrl.sra_en),
        .res    (sh_res)
    );

    rv32_alu_mul #(.XLEN(XLEN)) u_mul (
        .a         (op_a),
        .b         (op_b),
        .is_signed (ctrl.mul_signed),
        .lo        (mul_lo),
        .hi        (mul_hi)
    );

    always_comb begin
        case (ctrl.src)
            SRC_SUM:   result = sum;
            SRC_LT:    result = {{(XLEN-1){1'b0}}, lt};
            SRC_XOR:   result = op_a ^ op_b;
            SRC_OR:    result = op_a | op_b;
            SRC_AND:   result = op_a & op_b;
            SRC_SHIFT: result = sh_res;
            SRC_MULLO: result = mul_lo;
            SRC_MULHI: result = mul_hi;
            SRC_PASSB: result = op_b;
            default:   result = '0;
        endcase
    end

endmodule

// File: rtl/rv32_alu_chk.sv
module rv32_alu_chk #(
    parameter int XLEN = 32
) (
    input logic [XLEN-1:0] op_a,
    input logic [XLEN-1:0] op_b,
    input logic [3:0]      op_sel,
    input logic [XLEN-1:0] result
);

    localparam int SHW = $clog2(XLEN);
    localparam int MSB = XLEN - 1;

    logic signed [2*XLEN-1:0] p_s;
    logic [2*XLEN-1:0]        p_u;

    always_comb begin
        p_s = $signed(op_a) * $signed(op_b);
        p_u = {{XLEN{1'b0}}, op_a} * {{XLEN{1'b0}}, op_b};
        if (op_sel == 4'd0)
            a_r1_add_inverse: assert (result - op_b == op_a) else $error("R1 add");
        if (op_sel == 4'd12)
            a_r2_sub_inverse: assert (result + op_b == op_a) else $error("R2 sub");
        if (op_sel == 4'd4)
            a_r3_xor_undo: assert ((result ^ op_b) == op_a) else $error("R3 xor");
        if (op_sel == 4'd1)
            a_r4_sll_low_amt: assert (result == (op_a << op_b[SHW-1:0])) else $error("R4 sll");
        if (op_sel == 4'd5 && op_b[SHW-1:0] != '0)
            a_r5_srl_zero_top: assert (result[MSB] == 1'b0) else $error("R5 srl");
        if (op_sel == 4'd13)
            a_r6_sra_sign_kept: assert (result[MSB] == op_a[MSB]) else $error("R6 sra");
        if (op_sel == 4'd2)
            a_r7_slt_signed: assert (result == {{(XLEN-1){1'b0}}, $signed(op_a) < $signed(op_b)})
                else $error("R7 slt");
        if (op_sel == 4'd8)
            a_r8_mul_low: assert (result == p_u[XLEN-1:0]) else $error("R8 mul");
        if (op_sel == 4'd9)
            a_r9_mulh_signed: assert (result == p_s[2*XLEN-1:XLEN]) else $error("R9 mulh");
        if (op_sel == 4'd11)
            a_r10_mulhu_unsigned: assert (result == p_u[2*XLEN-1:XLEN]) else $error("R10 mulhu");
        if (op_sel == 4'd15)
            a_r11_pass_b: assert (result == op_b) else $error("R11 pass");
        if (op_sel == 4'd3 || op_sel == 4'd10 || op_sel == 4'd14)
            a_r12_unused_zero: assert (result == '0) else $error("R12 unused");
    end

endmodule

bind rv32_alu rv32_alu_chk #(.XLEN(XLEN)) chk_i (
    .op_a   (op_a),
    .op_b   (op_b),
    .op_sel (op_sel),
    .result (result)
);

// File: tb/rv32_alu_tb_top.sv
module rv32_alu_tb_top;

    logic        clk = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [3:0]  sel = '0;
    logic [31:0] res;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rv32_alu dut_i (
        .op_a   (a),
        .op_b   (b),
        .op_sel (sel),
        .result (res)
    );

    function automatic logic [31:0] model(input logic [3:0] s, input logic [31:0] x, input logic [31:0] y);
        logic [63:0]        pu;
        logic signed [63:0] ps;
        logic signed [31:0] xs;
        pu = {32'b0, x} * {32'b0, y};
        ps = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y});
        xs = x;
        case (s)
            4'd0:    return x + y;
            4'd1:    return x << y[4:0];
            4'd2:    return {31'b0, $signed(x) < $signed(y)};
            4'd4:    return x ^ y;
            4'd5:    return x >> y[4:0];
            4'd6:    return x | y;
            4'd7:    return x & y;
            4'd8:    return pu[31:0];
            4'd9:    return ps[63:32];
            4'd11:   return pu[63:32];
            4'd12:   return x - y;
            4'd13:   return xs >>> y[4:0];
            4'd15:   return y;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] s);
        case (s)
            4'd0:              return "R1";
            4'd12:             return "R2";
            4'd4, 4'd6, 4'd7:  return "R3";
            4'd1:              return "R4";
            4'd5:              return "R5";
            4'd13:             return "R6";
            4'd2:              return "R7";
            4'd8:              return "R8";
            4'd9:              return "R9";
            4'd11:             return "R10";
            4'd15:             return "R11";
            default:           return "R12";
        endcase
    endfunction

    task automatic expect_res(input string req, input logic [31:0] exp);
        checks++;
        if (res !== exp) begin
            fails++;
            $display("FAIL %s sel=%0d a=%h b=%h actual=%h expected=%h", req, sel, a, b, res, exp);
        end
    endtask

    task automatic run(input logic [3:0] s, input logic [31:0] x, input logic [31:0] y);
        @(posedge clk);
        sel = s;
        a   = x;
        b   = y;
        @(negedge clk);
        expect_res(tag(s), model(s, x, y));
    endtask

    task automatic directed(input logic [3:0] s, input logic [31:0] x, input logic [31:0] y,
                            input logic [31:0] exp, input string req);
        @(posedge clk);
        sel = s;
        a   = x;
        b   = y;
        @(negedge clk);
        expect_res(req, exp);
    endtask

    logic [31:0] corner [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h5555_5555};

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        expect_res("R1", 32'h0);   // idle inputs give zero
        // Hand-computed corner cases
        directed(4'd2,  32'h8000_0000, 32'h7FFF_FFFF, 32'h1, "R7");
        directed(4'd2,  32'h7FFF_FFFF, 32'h8000_0000, 32'h0, "R7");
        directed(4'd13, 32'h8000_0000, 32'd31, 32'hFFFF_FFFF, "R6");
        directed(4'd13, 32'h8000_0000, 32'd0, 32'h8000_0000, "R6");
        directed(4'd1,  32'h0000_0003, 32'hFFFF_FFE1, 32'h0000_0006, "R4");
        directed(4'd5,  32'h8000_0000, 32'd31, 32'h0000_0001, "R5");
        directed(4'd9,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R9");
        directed(4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R10");
        directed(4'd8,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, "R8");
        directed(4'd0,  32'hFFFF_FFFF, 32'h1, 32'h0, "R1");
        directed(4'd12, 32'h0, 32'h1, 32'hFFFF_FFFF, "R2");
        directed(4'd15, 32'h1234_5678, 32'hCAFE_F00D, 32'hCAFE_F00D, "R11");
        directed(4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R12");
        // Corner grid over every code
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    run(4'(s), corner[i], corner[j]);
        // Random operands
        for (int k = 0; k < 3000; k++)
            run(4'($urandom_range(15)), $urandom, $urandom);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule